// File: doc/BRIEF.md
# Serial loader command engine

This block runs the byte-level side of a serial firmware loader. It sits between a UART byte receiver and transmitter on one side and a flash job sequencer and a memory read port on the other. After reset it sends one acknowledge byte to the host. It then gives the host a bounded window, counted in clock cycles, to answer with the same acknowledge code. If the host answers correctly, the block acknowledges again and enters a loop that decodes one-byte commands.

The loop handles four commands. Erase takes a two-byte address, starts an erase job and acknowledges when the job completes. Write takes an address, a length and that many data bytes. The data bytes go into a local buffer that the flash sequencer reads while the program job runs, and the block acknowledges on completion. Read streams bytes from increasing memory addresses. Identify streams a fixed identification string. Neither read nor identify sends an acknowledge afterwards. The read command can be compiled out.

Any byte that is not a known command, the quit byte included, raises a sticky system reset request. A wrong handshake byte or an expired entry window raises the same request. Each job carries a bank select derived from the target address, so the sequencer drives the control registers of the correct flash bank.

Top module: `boot_cmd_engine`

## Requirements
- R1: After reset the block presents the acknowledge code (default 0xFC) on tx_data with tx_valid high. It does not raise rx_ready until a tx_ready handshake has taken that byte.
- R2: Once the first acknowledge has been taken, reset_req rises exactly ENTRY_WAIT clock cycles later if no byte has been received in that time.
- R3: If the first received byte differs from the acknowledge code, reset_req rises. If it matches, one acknowledge byte is sent and the command loop starts.
- R4: In the command loop, a byte other than erase (0x45), write (0x57), identify (0x49) or read (0x52) raises reset_req. The read code also raises reset_req when READ_EN is 0. Once high, reset_req stays high until rst, and the block then sends nothing, accepts nothing and starts no job.
- R5: Erase receives the address high byte and then the low byte. It then pulses job_start for one cycle with job_erase=1 and job_addr set to that address. After job_done it sends one acknowledge byte.
- R6: Write receives the address high byte, the low byte and a length byte, then exactly that many data bytes. Data byte k is stored at buffer offset k and can be read through buf_raddr/buf_rdata with one cycle of latency. Then job_start pulses with job_erase=0, job_addr and job_len, and one acknowledge follows job_done.
- R7: A length byte of 0 means 256 bytes, for both write (job_len=256) and read.
- R8: Read receives the address high byte, the low byte and a length byte. It then sends the bytes of mem_rdata for addresses addr, addr+1, and so on (16-bit wrap). Each byte is fetched with a one-cycle mem_rd pulse and taken one cycle later. No acknowledge follows.
- R9: Identify sends ID_LEN bytes whose values are ID_BASE+0, ID_BASE+1, and so on, and no acknowledge follows.
- R10: job_bank_low is 0 when job_addr is at or above BANK_SPLIT (0x8000) and 1 below it.
- R11: While tx_valid is high and tx_ready is low, tx_valid and tx_data stay unchanged.
- R12: rx_ready is low while a flash job is pending and whenever a byte is being sent. A byte offered with rx_ready low is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block takes rx_data on this cycle if rx_valid is high |
| tx_valid | output | 1 | Byte to send is presented |
| tx_data | output | 8 | Byte to send |
| tx_ready | input | 1 | Transmitter takes tx_data on this cycle |
| job_start | output | 1 | One-cycle start of a flash job |
| job_erase | output | 1 | 1 = erase job, 0 = program job |
| job_addr | output | 16 | Target flash address |
| job_len | output | LEN_W+1 | Program length in bytes (1..256) |
| job_bank_low | output | 1 | 1 selects the lower-address bank |
| job_done | input | 1 | Flash job finished |
| buf_raddr | input | LEN_W | Buffer read address for the sequencer |
| buf_rdata | output | 8 | Buffer data, one cycle after buf_raddr |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory data, valid the cycle after mem_rd |
| reset_req | output | 1 | Sticky system reset request |

## Verification
The assertions assume that job_done arrives only while a job is outstanding and that mem_rdata is valid on the cycle after mem_rd. They make no assumption about when tx_ready or rx_valid are asserted. The bench models memory as a registered lookup driven only by mem_rd, and it drives job_done only after it has seen job_start. It holds tx_ready off for several cycles before some handshakes, and it pushes bytes while rx_ready is low, so the handshake rules are exercised from both sides.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [3:0] {
    ST_HELLO, ST_WAIT, ST_ACK, ST_CMD, ST_AH, ST_AL, ST_LEN, ST_DATA,
    ST_JOB, ST_BUSY, ST_RD, ST_RDW, ST_RTX, ST_ID, ST_DEAD
  } state_t;

  typedef enum logic [1:0] {
    K_ERASE, K_WRITE, K_READ
  } kind_t;

  // Identification byte i is an ascending run from a base value.
  function automatic logic [7:0] id_char(input logic [7:0] base, input int unsigned i);
    return base + 8'(i);
  endfunction

endpackage

// File: rtl/boot_entry_timer.sv
module boot_entry_timer #(
  parameter int unsigned LIMIT = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/boot_wbuf.sv
module boot_wbuf #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/boot_cmd_engine.sv
module boot_cmd_engine
  import boot_pkg::*;
#(
  parameter int unsigned ENTRY_WAIT = 5_000_000,
  parameter int unsigned ID_LEN     = 8,
  parameter int unsigned LEN_W      = 8,
  parameter bit          READ_EN    = 1'b1,
  parameter logic [7:0]  CODE_ACK   = 8'hFC,
  parameter logic [7:0]  CODE_ERASE = 8'h45,
  parameter logic [7:0]  CODE_WRITE = 8'h57,
  parameter logic [7:0]  CODE_IDENT = 8'h49,
  parameter logic [7:0]  CODE_READ  = 8'h52,
  parameter logic [7:0]  ID_BASE    = 8'h30,
  parameter logic [15:0] BANK_SPLIT = 16'h8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  output logic             job_start,
  output logic             job_erase,
  output logic [15:0]      job_addr,
  output logic [LEN_W:0]   job_len,
  output logic             job_bank_low,
  input  logic             job_done,
  input  logic [LEN_W-1:0] buf_raddr,
  output logic [7:0]       buf_rdata,
  output logic             mem_rd,
  output logic [15:0]      mem_addr,
  input  logic [7:0]       mem_rdata,
  output logic             reset_req
);
  localparam int unsigned CW    = LEN_W + 1;
  localparam int unsigned IW    = $clog2(ID_LEN + 1);
  localparam int unsigned DEPTH = 1 << LEN_W;

  state_t           state;
  kind_t            kind;
  logic [7:0]       tx_byte;
  logic [15:0]      addr, ptr;
  logic [CW-1:0]    len_q, cnt;
  logic [LEN_W-1:0] widx;
  logic [IW-1:0]    idx;
  logic             rx_take, tx_take, expired, read_hit, buf_we;
  logic [CW-1:0]    len_in;

  assign rx_ready = (state == ST_WAIT) || (state == ST_CMD) || (state == ST_AH) ||
                    (state == ST_AL) || (state == ST_LEN) || (state == ST_DATA);
  assign tx_valid = (state == ST_HELLO) || (state == ST_ACK) ||
                    (state == ST_ID) || (state == ST_RTX);
  assign rx_take  = rx_valid && rx_ready;
  assign tx_take  = tx_valid && tx_ready;
  assign tx_data  = tx_byte;

  assign job_start    = (state == ST_JOB);
  assign job_erase    = (kind == K_ERASE);
  assign job_addr     = addr;
  assign job_len      = len_q;
  assign job_bank_low = (addr < BANK_SPLIT);
  assign mem_rd       = (state == ST_RD);
  assign mem_addr     = ptr;
  assign reset_req    = (state == ST_DEAD);

  // A zero length field stands for a full buffer.
  assign len_in = (rx_data[LEN_W-1:0] == '0) ? CW'(DEPTH) : {1'b0, rx_data[LEN_W-1:0]};

  generate
    if (READ_EN) begin : g_read
      assign read_hit = (rx_data == CODE_READ);
    end else begin : g_noread
      assign read_hit = 1'b0;
    end
  endgenerate

  boot_entry_timer #(.LIMIT(ENTRY_WAIT)) u_timer (
    .clk(clk), .rst(rst), .run(state == ST_WAIT), .expired(expired)
  );

  assign buf_we = (state == ST_DATA) && rx_take;

  boot_wbuf #(.AW(LEN_W), .DW(8)) u_buf (
    .clk(clk), .we(buf_we), .waddr(widx), .wdata(rx_data),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HELLO;
      kind    <= K_ERASE;
      tx_byte <= CODE_ACK;
      addr    <= '0;
      ptr     <= '0;
      len_q   <= '0;
      cnt     <= '0;
      widx    <= '0;
      idx     <= '0;
    end else begin
      case (state)
        ST_HELLO: if (tx_take) state <= ST_WAIT;
        ST_WAIT: begin
          if (rx_take) begin
            state   <= (rx_data == CODE_ACK) ? ST_ACK : ST_DEAD;
            tx_byte <= CODE_ACK;
          end else if (expired) begin
            state <= ST_DEAD;
          end
        end
        ST_ACK: if (tx_take) state <= ST_CMD;
        ST_CMD: begin
          if (rx_take) begin
            if (rx_data == CODE_ERASE) begin
              kind <= K_ERASE; state <= ST_AH;
            end else if (rx_data == CODE_WRITE) begin
              kind <= K_WRITE; state <= ST_AH;
            end else if (read_hit) begin
              kind <= K_READ; state <= ST_AH;
            end else if (rx_data == CODE_IDENT) begin
              idx     <= '0;
              tx_byte <= id_char(ID_BASE, 0);
              state   <= ST_ID;
            end else begin
              state <= ST_DEAD;
            end
          end
        end
        ST_AH: if (rx_take) begin
          addr[15:8] <= rx_data;
          state      <= ST_AL;
        end
        ST_AL: if (rx_take) begin
          addr[7:0] <= rx_data;
          state     <= (kind == K_ERASE) ? ST_JOB : ST_LEN;
        end
        ST_LEN: if (rx_take) begin
          len_q <= len_in;
          cnt   <= len_in;
          widx  <= '0;
          ptr   <= addr;
          state <= (kind == K_WRITE) ? ST_DATA : ST_RD;
        end
        ST_DATA: if (rx_take) begin
          widx <= widx + 1'b1;
          cnt  <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= ST_JOB;
        end
        ST_JOB:  state <= ST_BUSY;
        ST_BUSY: if (job_done) begin
          tx_byte <= CODE_ACK;
          state   <= ST_ACK;
        end
        ST_RD:  state <= ST_RDW;
        ST_RDW: begin
          tx_byte <= mem_rdata;
          state   <= ST_RTX;
        end
        ST_RTX: if (tx_take) begin
          ptr   <= ptr + 1'b1;
          cnt   <= cnt - 1'b1;
          state <= (cnt == CW'(1)) ? ST_CMD : ST_RD;
        end
        ST_ID: if (tx_take) begin
          if (idx == IW'(ID_LEN - 1)) begin
            state <= ST_CMD;
          end else begin
            idx     <= idx + 1'b1;
            tx_byte <= id_char(ID_BASE, int'(idx) + 1);
          end
        end
        default: state <= ST_DEAD;
      endcase
    end
  end
endmodule

// File: rtl/boot_cmd_checker.sv
module boot_cmd_checker (
  input logic       clk,
  input logic       rst,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       job_start,
  input logic       job_done,
  input logic       mem_rd,
  input logic       reset_req
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst)            pending <= 1'b0;
    else if (job_start) pending <= 1'b1;
    else if (job_done)  pending <= 1'b0;
  end

  a_r4_reset_sticky: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> reset_req);

  a_r4_quiet_after_req: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (!tx_valid && !rx_ready && !job_start && !mem_rd));

  a_r5_start_pulse: assert property (@(posedge clk) disable iff (rst)
    job_start |=> !job_start);

  a_r8_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  a_r11_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r12_idle_while_job: assert property (@(posedge clk) disable iff (rst)
    pending |-> (!tx_valid && !rx_ready));

  a_r12_one_direction: assert property (@(posedge clk) disable iff (rst)
    !(tx_valid && rx_ready));
endmodule

bind boot_cmd_engine boot_cmd_checker u_chk (
  .clk(clk), .rst(rst), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_ready(tx_ready), .job_start(job_start),
  .job_done(job_done), .mem_rd(mem_rd), .reset_req(reset_req)
);

// File: tb/boot_cmd_engine_test.sv
module boot_cmd_engine_test;
  localparam int W    = 40;
  localparam int IDL  = 4;
  localparam logic [7:0] ACK = 8'hFC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic rx_valid = 1'b0, tx_ready = 1'b0, job_done = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] buf_raddr = '0;
  logic rx_ready, tx_valid, job_start, job_erase, job_bank_low, mem_rd, reset_req;
  logic [7:0] tx_data, buf_rdata, mem_rdata;
  logic [15:0] job_addr, mem_addr;
  logic [8:0] job_len;

  boot_cmd_engine #(.ENTRY_WAIT(W), .ID_LEN(IDL)) uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .job_start(job_start), .job_erase(job_erase), .job_addr(job_addr), .job_len(job_len),
    .job_bank_low(job_bank_low), .job_done(job_done), .buf_raddr(buf_raddr),
    .buf_rdata(buf_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .reset_req(reset_req)
  );

  // Second instance with the read command compiled out.
  logic rx_valid2 = 1'b0;
  logic [7:0] rx_data2 = '0;
  logic rx_ready2, tx_valid2, js2, je2, jb2, mr2, reset_req2;
  logic [7:0] tx_data2, bd2;
  logic [15:0] ja2, ma2;
  logic [8:0] jl2;

  boot_cmd_engine #(.ENTRY_WAIT(W), .ID_LEN(IDL), .READ_EN(1'b0)) uut_nr (
    .clk(clk), .rst(rst), .rx_valid(rx_valid2), .rx_data(rx_data2), .rx_ready(rx_ready2),
    .tx_valid(tx_valid2), .tx_data(tx_data2), .tx_ready(1'b1),
    .job_start(js2), .job_erase(je2), .job_addr(ja2), .job_len(jl2),
    .job_bank_low(jb2), .job_done(1'b0), .buf_raddr(8'h00),
    .buf_rdata(bd2), .mem_rd(mr2), .mem_addr(ma2), .mem_rdata(8'h00),
    .reset_req(reset_req2)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return seed + 8'(7 * k);
  endfunction

  logic [7:0] mem_q = '0;
  always @(posedge clk) if (mem_rd) mem_q <= memf(mem_addr);
  assign mem_rdata = mem_q;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_byte(input logic [7:0] exp, input string req, input int hold);
    logic [7:0] d0;
    while (!tx_valid) @(negedge clk);
    if (hold > 0) begin
      d0 = tx_data;
      repeat (hold) @(negedge clk);
      chk(tx_valid && tx_data == d0, "R11 hold", int'(tx_data), int'(d0));
    end
    chk(tx_data == exp, req, int'(tx_data), int'(exp));
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic no_tx(input int n, input string req);
    bit seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (tx_valid) seen = 1'b1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  task automatic run_job(input bit er, input logic [15:0] a, input int len,
                         input bit low, input int n, input logic [7:0] seed);
    int errs = 0;
    while (!job_start) @(negedge clk);
    chk(job_erase == er, "R5/R6 job kind", int'(job_erase), int'(er));
    chk(job_addr == a, "R5/R6 job address", int'(job_addr), int'(a));
    chk(job_bank_low == low, "R10 bank select", int'(job_bank_low), int'(low));
    if (len > 0) chk(int'(job_len) == len, "R6/R7 job length", int'(job_len), len);
    // Offer a stray byte while the job is pending.
    rx_valid = 1'b1; rx_data = 8'h45;
    repeat (3) begin
      @(negedge clk);
      chk(!rx_ready, "R12 rx_ready low during job", int'(rx_ready), 0);
    end
    rx_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      buf_raddr = 8'(i);
      @(negedge clk);
      if (buf_rdata != pat(seed, i)) begin
        errs++;
        $display("FAIL R6 buffer[%0d] actual=%0h expected=%0h", i, buf_rdata, pat(seed, i));
      end
    end
    if (n > 0) begin
      checks++;
      if (errs != 0) fails++;
    end
    job_done = 1'b1;
    @(negedge clk);
    job_done = 1'b0;
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input logic [7:0] lb, input int n);
    int errs = 0;
    send(8'h52); send(a[15:8]); send(a[7:0]); send(lb);
    for (int i = 0; i < n; i++) begin
      logic [15:0] ai = a + 16'(i);
      while (!tx_valid) @(negedge clk);
      if (tx_data != memf(ai)) begin
        errs++;
        $display("FAIL R8 read byte %0d actual=%0h expected=%0h", i, tx_data, memf(ai));
      end
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
    checks++;
    if (errs != 0) fails++;
    no_tx(8, "R8 no acknowledge after read");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1: greeting presented, nothing received yet
    chk(tx_valid && tx_data == ACK, "R1 greeting", int'(tx_data), int'(ACK));
    chk(!rx_ready && !reset_req, "R1 rx_ready low", int'(rx_ready), 0);
    expect_byte(ACK, "R1 greeting byte", 3);
    send(ACK);
    expect_byte(ACK, "R3 handshake acknowledge", 0);

    // R9: identify, no trailing acknowledge
    send(8'h49);
    for (int i = 0; i < IDL; i++) expect_byte(8'h30 + 8'(i), "R9 id byte", (i == 1) ? 2 : 0);
    no_tx(8, "R9 no acknowledge after identify");

    // R5, R10: erase in both banks
    send(8'h45); send(8'h9A); send(8'hBC);
    run_job(1'b1, 16'h9ABC, 0, 1'b0, 0, 8'h00);
    expect_byte(ACK, "R5 erase acknowledge", 0);
    send(8'h45); send(8'h12); send(8'h34);
    run_job(1'b1, 16'h1234, 0, 1'b1, 0, 8'h00);
    expect_byte(ACK, "R5 erase acknowledge low bank", 2);

    // R6: short write just below the bank split
    send(8'h57); send(8'h7F); send(8'hFF); send(8'h05);
    for (int k = 0; k < 5; k++) send(pat(8'h03, k));
    run_job(1'b0, 16'h7FFF, 5, 1'b1, 5, 8'h03);
    expect_byte(ACK, "R6 write acknowledge", 0);

    // R7: zero length writes the full buffer at the split address
    send(8'h57); send(8'h80); send(8'h00); send(8'h00);
    for (int k = 0; k < 256; k++) send(pat(8'h0B, k));
    run_job(1'b0, 16'h8000, 256, 1'b0, 256, 8'h0B);
    expect_byte(ACK, "R7 full write acknowledge", 0);

    // R8, R7: reads with a carry into the high byte and a wrapping full read
    do_read(16'h12FE, 8'h04, 4);
    do_read(16'hFF80, 8'h00, 256);

    // R4: unknown command
    send(8'h00);
    repeat (2) @(negedge clk);
    chk(reset_req, "R4 unknown command", int'(reset_req), 1);
    no_tx(5, "R4 silent after request");
    chk(!rx_ready && reset_req, "R4 sticky request", int'(reset_req), 1);

    // R4 with read compiled out, then R3 mismatch on the main instance
    do_reset();
    @(negedge clk);
    rx_valid2 = 1'b1; rx_data2 = ACK;
    while (!rx_ready2) @(negedge clk);
    @(negedge clk);
    rx_valid2 = 1'b0;
    repeat (3) @(negedge clk);
    chk(!reset_req2, "R3 handshake on read-less instance", int'(reset_req2), 0);
    rx_valid2 = 1'b1; rx_data2 = 8'h52;
    while (!rx_ready2) @(negedge clk);
    @(negedge clk);
    rx_valid2 = 1'b0;
    @(negedge clk);
    chk(reset_req2, "R4 read disabled", int'(reset_req2), 1);

    expect_byte(ACK, "R1 greeting after reset", 0);
    send(8'h11);
    @(negedge clk);
    chk(reset_req, "R3 wrong handshake byte", int'(reset_req), 1);

    // R2: entry window timeout
    do_reset();
    expect_byte(ACK, "R1 greeting before timeout", 0);
    repeat (W - 1) @(negedge clk);
    chk(!reset_req, "R2 no request before window end", int'(reset_req), 0);
    @(negedge clk);
    chk(reset_req, "R2 request at window end", int'(reset_req), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule